// File: doc/BRIEF.md
# Text Hex Record Program Loader

This block turns a stream of ASCII characters carrying text hex records into writes on a program memory port. A host or receiver presents one character per cycle with a valid strobe. Each record opens with a colon, followed by hex digit pairs: a length, a 16-bit load address, a kind code, the payload bytes and a closing sum byte. Payload bytes of data records are paired into program words and written one after another from an internal pointer. The address field is decoded but has no effect on where words land.

After reset the loader first sweeps the whole program memory with zeros, one location per cycle. Only then does it accept characters. While loading it keeps a running 8-bit sum over every byte of a record and flags a record whose sum is not zero. It also flags any stray character inside a record, flags an attempt to write past the end of memory, and gives a single-cycle pulse when a well-formed end-of-file record closes.

Top module: `hexrec_loader`

## Requirements
- R1: After reset, `clearing` is high and the block writes zero to every address from 0 to DEPTH-1 in ascending order, one write per cycle. `clearing` falls in the cycle that shows the last of these writes. Characters presented while `clearing` is high are dropped and leave no trace.
- R2: A record starts at the character ':' (0x3A) and is read as hex digit pairs in this order: length byte, address high byte, address low byte, kind byte, payload bytes (as many as the length), sum byte. Digits 0-9, A-F and a-f are all accepted, and upper and lower case give the same value.
- R3: Only records of kind 0x00 write memory. Any other kind, including end-of-file (0x01), writes nothing.
- R4: A program word is formed from two consecutive payload bytes, the first being the low byte. The value written is the low 12 bits of first + 256*second, i.e. {second[3:0], first}.
- R5: Words are written at consecutive addresses from a pointer that starts at 0 after reset and carries on across records. The record's address field does not change it.
- R6: Pairing restarts at the start of each record. The last byte of a payload of odd length is discarded.
- R7: If the 8-bit sum of all bytes of a record, including the sum byte, is not zero, `err_sum` is set. It stays set until reset.
- R8: A character that is not a hex digit inside a record (this includes ':', CR and LF) sets `err_char`, which stays set until reset. The record is abandoned, so it produces no more writes and no sum check. The pointer keeps its value.
- R9: Outside a record, any character other than ':' (such as CR 0x0D, LF 0x0A or text) is ignored without error. No character is taken in a cycle where `in_valid` is low.
- R10: `load_done` is high for exactly one cycle, in the cycle after the last sum digit of an end-of-file record whose sum is correct. A record with a bad sum raises no pulse.
- R11: When a word would be written while the pointer equals DEPTH, no write occurs and `overflow` is set. It stays set until reset.
- R12: A word write is visible on the memory port for exactly one cycle, in the cycle after the clock edge that accepted the last digit of its second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is presented this cycle |
| in_char | input | 8 | ASCII character |
| clearing | output | 1 | Zero-fill sweep in progress; input is dropped |
| mem_we | output | 1 | Program memory write enable |
| mem_addr | output | ADDR_W (11) | Program memory write address |
| mem_data | output | WORD_W (12) | Program memory write data |
| load_done | output | 1 | One-cycle pulse when a good end-of-file record closes |
| err_sum | output | 1 | Sticky: a record failed its sum check |
| err_char | output | 1 | Sticky: a non-hex character appeared inside a record |
| overflow | output | 1 | Sticky: a word was refused because memory was full |

## Verification
Some properties are checked on every cycle. During the sweep each write carries zero. The three error flags never clear before reset. The done indication never lasts two cycles. A cycle without a valid character is never followed by a record write. The cycle in which overflow rises carries no write. The remaining behaviour depends on a whole record's content, so only the bench's scenarios can show it: word assembly and byte order, where words land, filtering by kind, dropping an odd final byte, detecting a bad sum, abandoning a record on a bad character, and the exact cycle of a write or done pulse. The bench rebuilds each record from its fields, computes the sum byte itself, and predicts every write.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_LOAD,
    ST_KIND,
    ST_BODY,
    ST_CHECK
  } rec_state_t;

  localparam logic [7:0] CH_START  = 8'h3A;
  localparam logic [7:0] KIND_DATA = 8'h00;
  localparam logic [7:0] KIND_END  = 8'h01;

  // Returns {digit_ok, nibble_value}
  function automatic logic [4:0] decode_digit(input logic [7:0] c);
    logic [4:0] r;
    if (c >= 8'h30 && c <= 8'h39)      r = {1'b1, 4'(c - 8'h30)};
    else if (c >= 8'h41 && c <= 8'h46) r = {1'b1, 4'(c - 8'h37)};
    else if (c >= 8'h61 && c <= 8'h66) r = {1'b1, 4'(c - 8'h57)};
    else                               r = 5'b0_0000;
    return r;
  endfunction

  function automatic logic [7:0] add8(input logic [7:0] a, input logic [7:0] b);
    return a + b;
  endfunction

  // Full 16-bit word, first byte low
  function automatic logic [15:0] join_word(input logic [7:0] first, input logic [7:0] second);
    return {second, first};
  endfunction

endpackage

// File: rtl/hexrec_charclass.sv
module hexrec_charclass
  import hexrec_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_start
);
  logic [4:0] dec;

  always_comb begin
    dec      = decode_digit(ch);
    is_hex   = dec[4];
    nib      = dec[3:0];
    is_start = (ch == CH_START);
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_stb,
  input  logic       is_hex,
  input  logic [3:0] nib,
  input  logic       is_start,
  output logic       rec_begin,
  output logic       data_stb,
  output logic [7:0] data_byte,
  output logic       load_done,
  output logic       err_sum,
  output logic       err_char
);
  rec_state_t state;
  logic [3:0] hi_nib;
  logic       have_hi;
  logic [7:0] left;
  logic [7:0] count;
  logic [7:0] kind;
  logic [7:0] sum;
  logic       done_q, esum_q, echar_q;

  // named internal events
  logic       in_rec;
  logic       digit_evt;
  logic       bad_evt;
  logic       byte_evt;
  logic [7:0] cur_byte;
  logic [7:0] sum_next;
  logic       close_evt;
  logic       sum_bad_evt;
  logic       eof_evt;

  always_comb begin
    in_rec      = (state != ST_IDLE);
    digit_evt   = ch_stb && in_rec && is_hex;
    bad_evt     = ch_stb && in_rec && !is_hex;
    byte_evt    = digit_evt && have_hi;
    cur_byte    = {hi_nib, nib};
    sum_next    = add8(sum, cur_byte);
    rec_begin   = ch_stb && !in_rec && is_start;
    data_stb    = byte_evt && (state == ST_BODY) && (kind == KIND_DATA);
    data_byte   = cur_byte;
    close_evt   = byte_evt && (state == ST_CHECK);
    sum_bad_evt = close_evt && (sum_next != 8'h00);
    eof_evt     = close_evt && (sum_next == 8'h00) && (kind == KIND_END);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hi_nib  <= '0;
      have_hi <= 1'b0;
      left    <= '0;
      count   <= '0;
      kind    <= '0;
      sum     <= '0;
      done_q  <= 1'b0;
      esum_q  <= 1'b0;
      echar_q <= 1'b0;
    end else begin
      done_q <= eof_evt;
      if (bad_evt)     echar_q <= 1'b1;
      if (sum_bad_evt) esum_q  <= 1'b1;

      if (rec_begin) begin
        state   <= ST_COUNT;
        have_hi <= 1'b0;
        sum     <= '0;
      end else if (bad_evt) begin
        state   <= ST_IDLE;
        have_hi <= 1'b0;
      end else if (digit_evt) begin
        if (!have_hi) begin
          hi_nib  <= nib;
          have_hi <= 1'b1;
        end else begin
          have_hi <= 1'b0;
          sum     <= sum_next;
          case (state)
            ST_COUNT: begin
              count <= cur_byte;
              left  <= 8'd2;
              state <= ST_LOAD;
            end
            ST_LOAD: begin
              left <= left - 8'd1;
              if (left == 8'd1) state <= ST_KIND;
            end
            ST_KIND: begin
              kind <= cur_byte;
              if (count == 8'd0) begin
                state <= ST_CHECK;
              end else begin
                left  <= count;
                state <= ST_BODY;
              end
            end
            ST_BODY: begin
              left <= left - 8'd1;
              if (left == 8'd1) state <= ST_CHECK;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign load_done = done_q;
  assign err_sum   = esum_q;
  assign err_char  = echar_q;
endmodule

// File: rtl/hexrec_wordpack.sv
module hexrec_wordpack
  import hexrec_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_begin,
  input  logic              data_stb,
  input  logic [7:0]        data_byte,
  output logic              clearing,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              overflow
);
  localparam int               PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0]  CAP   = PTR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);

  logic              clr_on;
  logic [ADDR_W-1:0] clr_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic [7:0]        lo_byte;
  logic              have_lo;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              ovf_q;

  // named internal events
  logic              pair_evt;
  logic              room;
  logic              write_go;
  logic              block_evt;
  logic [15:0]       full_word;

  always_comb begin
    pair_evt  = data_stb && have_lo;
    room      = (wr_ptr < CAP);
    write_go  = pair_evt && room;
    block_evt = pair_evt && !room;
    full_word = join_word(lo_byte, data_byte);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_on  <= 1'b1;
      clr_ptr <= '0;
      wr_ptr  <= '0;
      lo_byte <= '0;
      have_lo <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (clr_on) begin
        we_q    <= 1'b1;
        addr_q  <= clr_ptr;
        data_q  <= '0;
        clr_ptr <= clr_ptr + 1'b1;
        if (clr_ptr == LAST) clr_on <= 1'b0;
      end else if (write_go) begin
        we_q   <= 1'b1;
        addr_q <= wr_ptr[ADDR_W-1:0];
        data_q <= full_word[WORD_W-1:0];
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (block_evt) ovf_q <= 1'b1;

      if (rec_begin) begin
        have_lo <= 1'b0;
      end else if (data_stb) begin
        if (have_lo) begin
          have_lo <= 1'b0;
        end else begin
          lo_byte <= data_byte;
          have_lo <= 1'b1;
        end
      end
    end
  end

  assign clearing = clr_on;
  assign mem_we   = we_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter  int DEPTH  = 2048,
  parameter  int WORD_W = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              clearing,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              load_done,
  output logic              err_sum,
  output logic              err_char,
  output logic              overflow
);
  logic       ch_stb;
  logic       is_hex;
  logic [3:0] nib;
  logic       is_start;
  logic       rec_begin;
  logic       data_stb;
  logic [7:0] data_byte;

  assign ch_stb = in_valid && !clearing;

  hexrec_charclass u_class (
    .ch       (in_char),
    .is_hex   (is_hex),
    .nib      (nib),
    .is_start (is_start)
  );

  hexrec_parser u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_stb    (ch_stb),
    .is_hex    (is_hex),
    .nib       (nib),
    .is_start  (is_start),
    .rec_begin (rec_begin),
    .data_stb  (data_stb),
    .data_byte (data_byte),
    .load_done (load_done),
    .err_sum   (err_sum),
    .err_char  (err_char)
  );

  hexrec_wordpack #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_begin (rec_begin),
    .data_stb  (data_stb),
    .data_byte (data_byte),
    .clearing  (clearing),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .overflow  (overflow)
  );
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              clearing,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_data,
  input logic              load_done,
  input logic              err_sum,
  input logic              err_char,
  input logic              overflow
);
  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |=> (mem_we && mem_data == '0));

  // R7
  sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sum |=> err_sum);

  // R8
  char_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_char |=> err_char);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R11
  ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> !mem_we);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  // R9
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clearing) |=> !mem_we);
endmodule

bind hexrec_loader hexrec_loader_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .clearing  (clearing),
  .mem_we    (mem_we),
  .mem_data  (mem_data),
  .load_done (load_done),
  .err_sum   (err_sum),
  .err_char  (err_char),
  .overflow  (overflow)
);

// File: tb/hexrec_loader_tb_top.sv
`timescale 1ns/1ps
module hexrec_loader_tb_top;
  localparam int DEPTH = 2048;
  localparam int LOGN  = 4200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        clearing, mem_we, load_done, err_sum, err_char, overflow;
  logic [10:0] mem_addr;
  logic [11:0] mem_data;

  always #2.5 clk = ~clk;

  hexrec_loader dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .clearing(clearing), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .load_done(load_done), .err_sum(err_sum), .err_char(err_char), .overflow(overflow)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // write log and done counter, kept by one process
  logic [22:0] wlog [LOGN];
  int wn;
  int done_seen;
  always @(negedge clk) begin
    if (!rst_n) begin
      wn = 0;
      done_seen = 0;
    end else begin
      if (mem_we) begin
        if (wn < LOGN) wlog[wn] = {mem_addr, mem_data};
        wn++;
      end
      if (load_done) done_seen++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stimulus table
  typedef struct packed {
    logic [7:0]  cnt;
    logic [15:0] ad;
    logic [7:0]  ty;
    logic [31:0] dat;
    logic        lower;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 16'h0000, 8'h00, 32'h78563412, 1'b0},
    '{8'd2, 16'h1234, 8'h00, 32'h0000CDAB, 1'b1},
    '{8'd3, 16'hFFF0, 8'h00, 32'h00030201, 1'b0},
    '{8'd2, 16'h0000, 8'h04, 32'h0000FFFF, 1'b0},
    '{8'd0, 16'h0000, 8'h00, 32'h00000000, 1'b0},
    '{8'd1, 16'h0000, 8'h00, 32'h00000099, 1'b0},
    '{8'd2, 16'h0040, 8'h00, 32'h00002211, 1'b1},
    '{8'd0, 16'h0000, 8'h01, 32'h00000000, 1'b0}
  };

  logic [7:0] pay [16];

  function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic put(input logic [7:0] c);
    in_char = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit lower);
    put(hexch(b[7:4], lower));
    put(hexch(b[3:0], lower));
  endtask

  function automatic logic [7:0] sum_byte(input int cnt, input logic [15:0] ad, input logic [7:0] ty);
    int s;
    s = cnt + int'(ad[15:8]) + int'(ad[7:0]) + int'(ty);
    for (int i = 0; i < cnt; i++) s += int'(pay[i]);
    return 8'((256 - (s % 256)) % 256);
  endfunction

  task automatic send_rec(input int cnt, input logic [15:0] ad, input logic [7:0] ty,
                          input bit bad, input bit lower);
    logic [7:0] s;
    s = sum_byte(cnt, ad, ty);
    if (bad) s = s ^ 8'h01;
    put(8'h3A);
    put_byte(8'(cnt), lower);
    put_byte(ad[15:8], lower);
    put_byte(ad[7:0], lower);
    put_byte(ty, lower);
    for (int i = 0; i < cnt; i++) put_byte(pay[i], lower);
    put_byte(s, lower);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_clear();
    while (clearing) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int mptr;
    int base;
    int bad;
    int np;
    string rq;
    @(negedge clk);

    // reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "clearing in reset", int'(clearing), 1);
    chk("R1", "we in reset", int'(mem_we), 0);
    chk("R7", "err_sum in reset", int'(err_sum), 0);
    chk("R8", "err_char in reset", int'(err_char), 0);
    chk("R11", "overflow in reset", int'(overflow), 0);
    chk("R10", "done in reset", int'(load_done), 0);
    rst_n = 1'b1;

    // a record sent during the sweep must leave no trace
    pay[0] = 8'hAA; pay[1] = 8'hBB;
    send_rec(2, 16'h0000, 8'h00, 0, 0);
    wait_clear();
    chk("R1", "sweep write count", wn, DEPTH);
    bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (wlog[i] != {11'(i), 12'h000}) bad++;
    chk("R1", "sweep order and zero data", bad, 0);
    chk("R1", "input during sweep no error", int'(err_sum | err_char), 0);

    // table walk
    mptr = 0;
    for (int v = 0; v < NV; v++) begin
      // separators and idle cycles between records
      put(8'h0D); put(8'h0A); put(8'h78);
      in_char = 8'h3A; @(negedge clk);
      in_char = 8'h31; @(negedge clk);
      for (int i = 0; i < 4; i++) pay[i] = VECS[v].dat[8*i +: 8];
      base = wn;
      send_rec(int'(VECS[v].cnt), VECS[v].ad, VECS[v].ty, 0, VECS[v].lower);
      chk("R10", $sformatf("done after vec %0d", v), int'(load_done),
          (VECS[v].ty == 8'h01) ? 1 : 0);
      @(negedge clk);
      np = (VECS[v].ty == 8'h00) ? int'(VECS[v].cnt) / 2 : 0;
      rq = (VECS[v].ty != 8'h00) ? "R3" : ((VECS[v].cnt % 2 != 0) ? "R6" : "R5");
      chk(rq, $sformatf("write count vec %0d", v), wn - base, np);
      for (int p = 0; p < np; p++) begin
        chk(VECS[v].lower ? "R2" : "R4", $sformatf("word %0d vec %0d", p, v),
            int'(wlog[base + p]),
            int'({11'(mptr), pay[2*p+1][3:0], pay[2*p]}));
        mptr++;
      end
    end
    chk("R9", "separators raise no char error", int'(err_char), 0);
    chk("R7", "good sums raise no sum error", int'(err_sum), 0);
    chk("R10", "one done pulse in table", done_seen, 1);

    // write timing, digit by digit
    put(8'h3A);
    put_byte(8'h02, 0); put_byte(8'h00, 0); put_byte(8'h00, 0); put_byte(8'h00, 0);
    put_byte(8'h34, 0);
    put(8'h31);
    chk("R12", "no write before final digit", int'(mem_we), 0);
    put(8'h32);
    chk("R12", "write after final digit", int'(mem_we), 1);
    chk("R12", "write data", int'(mem_data), 12'h234);
    chk("R5", "write address continues", int'(mem_addr), mptr);
    mptr++;
    put(8'h42);
    chk("R12", "write lasts one cycle", int'(mem_we), 0);
    put(8'h38);

    // bad sum
    base = wn;
    pay[0] = 8'h55; pay[1] = 8'h66;
    send_rec(2, 16'h0000, 8'h00, 1, 0);
    @(negedge clk);
    chk("R7", "bad sum flagged", int'(err_sum), 1);
    chk("R7", "streamed write still made", wn - base, 1);
    base = done_seen;
    send_rec(0, 16'h0000, 8'h01, 1, 0);
    @(negedge clk);
    chk("R10", "no done on bad end record", done_seen - base, 0);
    send_rec(0, 16'h0000, 8'h00, 0, 0);
    @(negedge clk);
    chk("R7", "sum flag sticky", int'(err_sum), 1);

    // bad character
    do_reset();
    chk("R8", "flags cleared by reset", int'(err_sum | err_char), 0);
    wait_clear();
    base = wn;
    put(8'h3A);
    put_byte(8'h04, 0); put_byte(8'h00, 0); put_byte(8'h00, 0); put_byte(8'h00, 0);
    put_byte(8'h11, 0); put_byte(8'h22, 0);
    put(8'h47);
    put_byte(8'h33, 0); put_byte(8'h44, 0); put_byte(8'hFF, 0);
    put(8'h0D); put(8'h0A);
    @(negedge clk);
    chk("R8", "char error flagged", int'(err_char), 1);
    chk("R8", "abandoned record writes", wn - base, 1);
    chk("R8", "write before bad char", int'(wlog[base]), int'({11'd0, 12'h211}));
    chk("R8", "no sum check on abandoned", int'(err_sum), 0);
    pay[0] = 8'h01; pay[1] = 8'h02;
    send_rec(2, 16'h0000, 8'h00, 0, 0);
    @(negedge clk);
    chk("R8", "pointer kept after abandon", int'(wlog[base + 1]), int'({11'd1, 12'h201}));

    // overflow
    do_reset();
    wait_clear();
    base = wn;
    for (int r = 0; r < DEPTH / 8; r++) begin
      for (int i = 0; i < 16; i++) pay[i] = 8'(r + i);
      send_rec(16, 16'h0000, 8'h00, 0, 0);
    end
    @(negedge clk);
    chk("R11", "no overflow at exact fill", int'(overflow), 0);
    chk("R11", "fill write count", wn - base, DEPTH);
    chk("R5", "last fill address", int'(wlog[base + DEPTH - 1][22:12]), DEPTH - 1);
    pay[0] = 8'h12; pay[1] = 8'h34;
    send_rec(2, 16'h0000, 8'h00, 0, 0);
    @(negedge clk);
    chk("R11", "overflow flagged", int'(overflow), 1);
    chk("R11", "refused write", wn - base, DEPTH);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule